// File: doc/BRIEF.md
# DRAM Timing Derivation Unit

This unit turns the raw timing bytes of a memory module descriptor into the settings a DDR controller needs. It takes the bit mask of supported CAS latencies, the cycle time at the highest CAS latency and at the two lower latencies, and the minimum row precharge (tRP), row-to-column delay (tRCD) and active-to-precharge (tRAS) times. From these it produces one packed timing byte and one clock-select code.

The unit picks the lowest CAS latency that still runs at the full clock rate. It sorts the full-rate cycle time into one of three speed grades, which set a period unit. Each minimum time then becomes a clock count by comparison against whole multiples of that period unit. Boot logic loads the descriptor bytes and pulses `start`. Two clock edges later `done` rises with the results, and both stay put until the next pulse.

Top module: `dts_timing_deriver`

## Requirements
- R1: `start` sampled high at a clock edge captures all descriptor inputs and clears `done` at that edge. At the next edge the results are loaded and `done` goes high.
- R2: While `start` stays low after a result, `done`, `timing_cfg` and `clk_sel` keep their values, whatever the descriptor inputs do.
- R3: With mask bit 4 (CAS 3 support) set, the latency starts at 3. It becomes 2.5 if mask bit 3 is set and `tck_alt1` <= `tck_max`. It then becomes 2 if mask bit 2 is set and `tck_alt2` <= `tck_max`, whatever the 2.5 step decided.
- R4: With mask bit 4 clear, the latency is 2.5, or 2 if mask bit 2 is set and `tck_alt1` <= `tck_max`.
- R5: The CAS latency is coded in `timing_cfg[5:4]` as 01 for 2, 10 for 2.5 and 11 for 3. The field is never 00 in a result.
- R6: The period unit is 20 for `tck_max` <= 0x50, 24 for `tck_max` <= 0x60 and 30 above that. `clk_sel` is 0x85, 0x81 and 0x80 for the same three ranges.
- R7: `timing_cfg[1:0]` is 3, 2 or 1 when `trp_min` is at least 5, 4 or 3 period units, checked in that order, and 0 otherwise.
- R8: `timing_cfg[3:2]` follows the rule of R7 applied to `trcd_min`.
- R9: `timing_cfg[7:6]` is 3, 2 or 1 when `tras_min` is at least 9, 8 or 7 times the period unit shifted right by two bits, checked in that order, and 0 otherwise.
- R10: During reset and until the first result, `done`, `timing_cfg` and `clk_sel` are zero.
- R11: All comparisons are unsigned and wide enough that the largest product (5 x 30 = 150, 9 x 7 = 63) and the largest input byte 0xFF compare without wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture the descriptor inputs and begin a derivation |
| cas_mask | input | 8 | Supported CAS latency mask (bit 2: 2, bit 3: 2.5, bit 4: 3) |
| tck_max | input | 8 | Cycle time at the highest CAS latency (ns nibble, tenth-ns nibble) |
| tck_alt1 | input | 8 | Cycle time one CAS step lower |
| tck_alt2 | input | 8 | Cycle time two CAS steps lower |
| trp_min | input | 8 | Minimum row precharge time |
| trcd_min | input | 8 | Minimum row-to-column delay |
| tras_min | input | 8 | Minimum active-to-precharge time |
| timing_cfg | output | 8 | Packed result {tRAS, CAS, tRCD, tRP}, 2 bits each |
| clk_sel | output | 8 | Clock-select code for the speed grade |
| done | output | 1 | Results valid |

## Verification
The bench sweeps every minimum-time byte from 0 to 255 in each of the three speed grades. A single off-by-one threshold, a strict compare where an inclusive one belongs, or a tRAS unit left unshifted would show up as a wrong 2-bit count at one edge value. The CAS sweep covers all support masks against alternate cycle times just below, equal to and above the full-rate time. A design that makes the 2-step depend on the 2.5-step, or that uses the wrong alternate byte when CAS 3 is absent, reports the wrong latency code. Grade boundaries 0x50/0x51 and 0x60/0x61 catch a misplaced range edge. Input changes without a start pulse catch a design that passes inputs straight through to its outputs.

// File: rtl/dts_pkg.sv
package dts_pkg;

  localparam int BYTE_W = 8;

  // CAS support mask bit positions
  localparam int CAS_BIT_2   = 2;
  localparam int CAS_BIT_2P5 = 3;
  localparam int CAS_BIT_3   = 4;

  // speed grade range limits on the full-rate cycle time byte
  localparam logic [BYTE_W-1:0] GRADE_FAST_MAX = 8'h50;
  localparam logic [BYTE_W-1:0] GRADE_MID_MAX  = 8'h60;

  // period units per grade
  localparam logic [BYTE_W-1:0] UNIT_FAST = 8'h14;
  localparam logic [BYTE_W-1:0] UNIT_MID  = 8'h18;
  localparam logic [BYTE_W-1:0] UNIT_SLOW = 8'h1E;

  // clock-select codes per grade
  localparam logic [BYTE_W-1:0] SEL_FAST = 8'h85;
  localparam logic [BYTE_W-1:0] SEL_MID  = 8'h81;
  localparam logic [BYTE_W-1:0] SEL_SLOW = 8'h80;

  typedef enum logic [1:0] {
    CL_NONE = 2'b00,
    CL_2    = 2'b01,
    CL_2P5  = 2'b10,
    CL_3    = 2'b11
  } cas_code_t;

  typedef struct packed {
    logic [BYTE_W-1:0] cas_mask;
    logic [BYTE_W-1:0] tck_max;
    logic [BYTE_W-1:0] tck_alt1;
    logic [BYTE_W-1:0] tck_alt2;
    logic [BYTE_W-1:0] trp;
    logic [BYTE_W-1:0] trcd;
    logic [BYTE_W-1:0] tras;
  } dts_desc_t;

endpackage

// File: rtl/dts_cas_select.sv
module dts_cas_select
  import dts_pkg::*;
(
  input  logic [BYTE_W-1:0] cas_mask,
  input  logic [BYTE_W-1:0] tck_max,
  input  logic [BYTE_W-1:0] tck_alt1,
  input  logic [BYTE_W-1:0] tck_alt2,
  output cas_code_t         cas
);

  logic alt1_ok;
  logic alt2_ok;

  assign alt1_ok = (tck_alt1 <= tck_max);
  assign alt2_ok = (tck_alt2 <= tck_max);

  always_comb begin
    if (cas_mask[CAS_BIT_3]) begin
      cas = CL_3;
      if (cas_mask[CAS_BIT_2P5] && alt1_ok) cas = CL_2P5;
      // the 2 step is judged on its own, not gated by the 2.5 step
      if (cas_mask[CAS_BIT_2] && alt2_ok)   cas = CL_2;
    end else begin
      cas = CL_2P5;
      if (cas_mask[CAS_BIT_2] && alt1_ok)   cas = CL_2;
    end
  end

endmodule

// File: rtl/dts_period_quant.sv
module dts_period_quant
  import dts_pkg::*;
#(
  parameter int CMP_W = 10
) (
  input  logic [BYTE_W-1:0] tck_max,
  output logic [CMP_W-1:0]  unit,
  output logic [BYTE_W-1:0] clk_sel
);

  always_comb begin
    if (tck_max <= GRADE_FAST_MAX) begin
      unit    = CMP_W'(UNIT_FAST);
      clk_sel = SEL_FAST;
    end else if (tck_max <= GRADE_MID_MAX) begin
      unit    = CMP_W'(UNIT_MID);
      clk_sel = SEL_MID;
    end else begin
      unit    = CMP_W'(UNIT_SLOW);
      clk_sel = SEL_SLOW;
    end
  end

endmodule

// File: rtl/dts_timing_field.sv
module dts_timing_field
  import dts_pkg::*;
#(
  parameter int CMP_W     = 10,
  parameter int BASE_MULT = 3,
  parameter int SHIFT     = 0,
  parameter int STEPS     = 3,
  localparam int CODE_W   = $clog2(STEPS + 1)
) (
  input  logic [BYTE_W-1:0] min_val,
  input  logic [CMP_W-1:0]  unit,
  output logic [CODE_W-1:0] code
);

  logic [CMP_W-1:0] unit_s;
  logic [CMP_W-1:0] val_w;
  logic [STEPS-1:0] hit;

  assign unit_s = unit >> SHIFT;
  assign val_w  = CMP_W'(min_val);

  for (genvar k = 0; k < STEPS; k++) begin : g_step
    logic [CMP_W-1:0] limit;
    assign limit  = CMP_W'((BASE_MULT + k) * unit_s);
    assign hit[k] = (val_w >= limit);
  end

  // thresholds rise with k, so the highest hit gives the count
  always_comb begin
    code = '0;
    for (int k = 0; k < STEPS; k++) begin
      if (hit[k]) code = CODE_W'(k + 1);
    end
  end

endmodule

// File: rtl/dts_timing_deriver.sv
module dts_timing_deriver
  import dts_pkg::*;
#(
  parameter int CMP_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] cas_mask,
  input  logic [BYTE_W-1:0] tck_max,
  input  logic [BYTE_W-1:0] tck_alt1,
  input  logic [BYTE_W-1:0] tck_alt2,
  input  logic [BYTE_W-1:0] trp_min,
  input  logic [BYTE_W-1:0] trcd_min,
  input  logic [BYTE_W-1:0] tras_min,
  output logic [BYTE_W-1:0] timing_cfg,
  output logic [BYTE_W-1:0] clk_sel,
  output logic              done
);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  dts_desc_t         desc_q, desc_d;
  logic              pend_q, pend_d;
  logic [BYTE_W-1:0] cfg_q, cfg_d;
  logic [BYTE_W-1:0] sel_q, sel_d;
  logic              done_q, done_d;

  cas_code_t         cas_c;
  logic [CMP_W-1:0]  unit_c;
  logic [BYTE_W-1:0] sel_c;
  logic [1:0]        trp_c, trcd_c, tras_c;

  dts_cas_select u_cas (
    .cas_mask (desc_q.cas_mask),
    .tck_max  (desc_q.tck_max),
    .tck_alt1 (desc_q.tck_alt1),
    .tck_alt2 (desc_q.tck_alt2),
    .cas      (cas_c)
  );

  dts_period_quant #(.CMP_W(CMP_W)) u_quant (
    .tck_max (desc_q.tck_max),
    .unit    (unit_c),
    .clk_sel (sel_c)
  );

  dts_timing_field #(.CMP_W(CMP_W), .BASE_MULT(3), .SHIFT(0)) u_trp (
    .min_val (desc_q.trp),
    .unit    (unit_c),
    .code    (trp_c)
  );

  dts_timing_field #(.CMP_W(CMP_W), .BASE_MULT(3), .SHIFT(0)) u_trcd (
    .min_val (desc_q.trcd),
    .unit    (unit_c),
    .code    (trcd_c)
  );

  dts_timing_field #(.CMP_W(CMP_W), .BASE_MULT(7), .SHIFT(2)) u_tras (
    .min_val (desc_q.tras),
    .unit    (unit_c),
    .code    (tras_c)
  );

  logic ld_desc;
  logic ld_out;

  assign ld_desc = start;
  assign ld_out  = pend_q && !start;

  always_comb begin
    desc_d = desc_q;
    pend_d = pend_q;
    cfg_d  = cfg_q;
    sel_d  = sel_q;
    done_d = done_q;
    if (ld_desc) begin
      desc_d = '{cas_mask: cas_mask, tck_max: tck_max, tck_alt1: tck_alt1,
                 tck_alt2: tck_alt2, trp: trp_min, trcd: trcd_min,
                 tras: tras_min};
      pend_d = 1'b1;
      done_d = 1'b0;
    end else if (ld_out) begin
      cfg_d  = {tras_c, cas_c, trcd_c, trp_c};
      sel_d  = sel_c;
      pend_d = 1'b0;
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      desc_q <= '0;
      pend_q <= 1'b0;
      cfg_q  <= '0;
      sel_q  <= '0;
      done_q <= 1'b0;
    end else begin
      desc_q <= desc_d;
      pend_q <= pend_d;
      cfg_q  <= cfg_d;
      sel_q  <= sel_d;
      done_q <= done_d;
    end
  end

  assign timing_cfg = cfg_q;
  assign clk_sel    = sel_q;
  assign done       = done_q;

endmodule

// File: rtl/dts_checker.sv
module dts_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [7:0] timing_cfg,
  input logic [7:0] clk_sel,
  input logic       done
);

  assert_start_clears_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);

  assert_done_from_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(start, 2));

  assert_hold_results_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(timing_cfg) && $stable(clk_sel)));

  assert_cas_field_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (timing_cfg[5:4] != 2'b00));

  assert_clk_sel_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (clk_sel == 8'h85 || clk_sel == 8'h81 || clk_sel == 8'h80));

  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !$past(done)) |-> (clk_sel == $past(clk_sel)));

endmodule

bind dts_timing_deriver dts_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .timing_cfg (timing_cfg),
  .clk_sel    (clk_sel),
  .done       (done)
);

// File: tb/tb_dts_timing_deriver.sv
module tb_dts_timing_deriver;

  logic       clk;
  logic       rst_n;
  logic       start;
  logic [7:0] cas_mask, tck_max, tck_alt1, tck_alt2;
  logic [7:0] trp_min, trcd_min, tras_min;
  logic [7:0] timing_cfg, clk_sel;
  logic       done;

  int checks;
  int errors;
  bit finished;

  dts_timing_deriver dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cas_mask   (cas_mask),
    .tck_max    (tck_max),
    .tck_alt1   (tck_alt1),
    .tck_alt2   (tck_alt2),
    .trp_min    (trp_min),
    .trcd_min   (trcd_min),
    .tras_min   (tras_min),
    .timing_cfg (timing_cfg),
    .clk_sel    (clk_sel),
    .done       (done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input string what,
                       input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, actual, expected);
    end
  endtask

  function automatic int ref_unit(input int t);
    if (t <= 'h50) return 20;
    if (t <= 'h60) return 24;
    return 30;
  endfunction

  function automatic int ref_sel(input int t);
    if (t <= 'h50) return 'h85;
    if (t <= 'h60) return 'h81;
    return 'h80;
  endfunction

  function automatic int ref_cas(input logic [7:0] m, input int mx, input int a1, input int a2);
    int c;
    if (m[4]) begin
      c = 3;
      if (m[3] && a1 <= mx) c = 2;
      if (m[2] && a2 <= mx) c = 1;
    end else begin
      c = 2;
      if (m[2] && a1 <= mx) c = 1;
    end
    return c;
  endfunction

  function automatic int ref_field(input int v, input int u, input int base);
    int n = 0;
    for (int k = 0; k < 3; k++) if (v >= (base + k) * u) n = k + 1;
    return n;
  endfunction

  task automatic run(input logic [7:0] m, input logic [7:0] mx, input logic [7:0] a1,
                     input logic [7:0] a2, input logic [7:0] rp, input logic [7:0] rcd,
                     input logic [7:0] ras, input string rtag);
    int u;
    @(negedge clk);
    cas_mask = m; tck_max = mx; tck_alt1 = a1; tck_alt2 = a2;
    trp_min = rp; trcd_min = rcd; tras_min = ras;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R1", "done low after start", done, 0);
    @(negedge clk);
    u = ref_unit(mx);
    check("R1", "done high", done, 1);
    check(m[4] ? "R3" : "R4", "cas field R5", timing_cfg[5:4], ref_cas(m, mx, a1, a2));
    check("R6", "clk_sel", clk_sel, ref_sel(mx));
    check(rtag == "" ? "R7" : rtag, "trp field", timing_cfg[1:0], ref_field(rp, u, 3));
    check(rtag == "" ? "R8" : rtag, "trcd field", timing_cfg[3:2], ref_field(rcd, u, 3));
    check(rtag == "" ? "R9" : rtag, "tras field", timing_cfg[7:6], ref_field(ras, u >> 2, 7));
  endtask

  logic [7:0] grade_tck [7];
  logic [7:0] snap_cfg, snap_sel;

  initial begin
    checks = 0; errors = 0; finished = 0;
    rst_n = 1'b0; start = 1'b0;
    cas_mask = '0; tck_max = '0; tck_alt1 = '0; tck_alt2 = '0;
    trp_min = '0; trcd_min = '0; tras_min = '0;
    repeat (3) @(negedge clk);
    check("R10", "reset done", done, 0);
    check("R10", "reset cfg", timing_cfg, 0);
    check("R10", "reset sel", clk_sel, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10", "idle done", done, 0);
    check("R10", "idle cfg", timing_cfg, 0);
    check("R10", "idle sel", clk_sel, 0);

    grade_tck = '{8'h00, 8'h4F, 8'h50, 8'h51, 8'h60, 8'h61, 8'hFF};

    // R7 R8 R9: every byte value in each grade
    foreach (grade_tck[g]) begin
      if (g == 1 || g == 4 || g == 6) begin
        for (int v = 0; v < 256; v++)
          run(8'h1C, grade_tck[g], 8'hFF, 8'hFF, 8'(v), 8'(255 - v), 8'(v), "");
      end
    end

    // R3 R4 R5 R6: masks against alternate cycle times below, equal, above
    foreach (grade_tck[g]) begin
      for (int mi = 0; mi < 8; mi++) begin
        for (int r1 = 0; r1 < 3; r1++) begin
          for (int r2 = 0; r2 < 3; r2++) begin
            logic [7:0] a1, a2;
            a1 = (r1 == 0) ? grade_tck[g] - 8'(grade_tck[g] != 0) :
                 (r1 == 1) ? grade_tck[g] : grade_tck[g] + 8'(grade_tck[g] != 8'hFF);
            a2 = (r2 == 0) ? grade_tck[g] - 8'(grade_tck[g] != 0) :
                 (r2 == 1) ? grade_tck[g] : grade_tck[g] + 8'(grade_tck[g] != 8'hFF);
            run(8'(mi << 2), grade_tck[g], a1, a2, 8'h50, 8'h3C, 8'h30, "");
          end
        end
      end
    end

    // R11: largest inputs in the slowest grade must not wrap
    run(8'h10, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, "R11");
    run(8'h10, 8'h61, 8'h00, 8'h00, 8'd149, 8'd150, 8'd62, "R11");

    // R2: inputs move without start; results and done must hold
    run(8'h14, 8'h55, 8'h50, 8'h70, 8'd80, 8'd70, 8'd45, "");
    snap_cfg = timing_cfg; snap_sel = clk_sel;
    @(negedge clk);
    cas_mask = 8'h08; tck_max = 8'hA0; tck_alt1 = 8'hFF; tck_alt2 = 8'hFF;
    trp_min = 8'h00; trcd_min = 8'hFF; tras_min = 8'h00;
    repeat (4) @(negedge clk);
    check("R2", "held done", done, 1);
    check("R2", "held cfg", timing_cfg, snap_cfg);
    check("R2", "held sel", clk_sel, snap_sel);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule